// File: doc/BRIEF.md
# Instruction fetch trace filter

This block sits next to a processor's fetch unit and picks which instruction fetches appear as show cycles on an external trace bus. In every cycle it sees a fetch-valid strobe. With that strobe come two flags: one says the fetch starts a change of flow, and the other says whether that change is indirect or direct. A 2-bit mode field sets how wide the filter is. The widest setting shows every fetch and the narrowest shows none.

A separate level input, the trace sync, does two jobs. First, when the mode is set to "off", a high sync level reopens the filter for indirect changes of flow. Second, every toggle of sync produces one marked trace-cycle request on its own output, and this happens whatever the fetch traffic is doing. Both outputs are registered and appear one clock after the inputs that cause them.

Top module: `fetch_trace_filter`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `show_req` and `mark_req` are 0.
- R2: With `show_mode` = 2'b00, every cycle with `fetch_vld` = 1 gives `show_req` = 1 in the next cycle.
- R3: With `show_mode` = 2'b01, `show_req` follows a valid fetch only when `fetch_cof` = 1. The value of `fetch_ind` makes no difference.
- R4: With `show_mode` = 2'b10, `show_req` follows a valid fetch only when both `fetch_cof` = 1 and `fetch_ind` = 1.
- R5: With `show_mode` = 2'b11 and `sync_in` = 0 in the fetch cycle, `show_req` stays 0 for every kind of fetch.
- R6: With `show_mode` = 2'b11 and `sync_in` = 1 in the fetch cycle, the filter behaves as in R4.
- R7: In any cycle where `sync_in` differs from its value in the previous cycle, rising or falling, `mark_req` is 1 for exactly the next cycle. In any cycle where `sync_in` is unchanged, `mark_req` is 0 in the next cycle.
- R8: A cycle with `fetch_vld` = 0 gives `show_req` = 0 in the next cycle, in every mode and for any flag values.
- R9: If a qualifying fetch and a sync toggle happen in the same cycle, both `show_req` and `mark_req` are 1 in the next cycle.
- R10: Holding `sync_in` high through reset does not produce a `mark_req` pulse after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_vld | input | 1 | An instruction fetch occurs in this cycle |
| fetch_cof | input | 1 | The fetch is a change of flow |
| fetch_ind | input | 1 | The change of flow is indirect (1) or direct (0) |
| show_mode | input | 2 | Filter setting: 00 all, 01 any change of flow, 10 indirect only, 11 off unless sync is high |
| sync_in | input | 1 | Trace sync level |
| show_req | output | 1 | Show-cycle request for the fetch of the previous cycle |
| mark_req | output | 1 | Marked trace-cycle request for a sync toggle in the previous cycle |

## Verification
In every mode the bench sends the same four fetch kinds: sequential, direct change of flow, indirect change of flow, and an indirect flag raised without a change of flow. This tells apart a filter that tests the flow flag, one that tests the indirect flag, and one that tests both. Mode 11 is run twice, once with sync low and once with sync high, so the level override shows up separately from mode 10. Sync is toggled in isolated cycles, in consecutive cycles, and together with qualifying fetches. This catches a missed edge, a pulse longer than one cycle, and one output blocking the other. Reset is also released with sync held high, to expose a stale edge history.

// File: rtl/fetch_trace_filter.sv
module fetch_trace_filter (
  input  logic       clk,
  input  logic       rst,
  input  logic       fetch_vld,
  input  logic       fetch_cof,
  input  logic       fetch_ind,
  input  logic [1:0] show_mode,
  input  logic       sync_in,
  output logic       show_req,
  output logic       mark_req
);

  logic sync_q;
  logic ind_cof;
  logic qualify;
  logic sync_edge;

  assign ind_cof   = fetch_cof & fetch_ind;
  assign sync_edge = sync_in ^ sync_q;

  always_comb begin
    unique case (show_mode)
      2'b00:   qualify = 1'b1;
      2'b01:   qualify = fetch_cof;
      2'b10:   qualify = ind_cof;
      default: qualify = ind_cof & sync_in;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q   <= sync_in;
      show_req <= 1'b0;
      mark_req <= 1'b0;
    end else begin
      sync_q   <= sync_in;
      show_req <= fetch_vld & qualify;
      mark_req <= sync_edge;
    end
  end

endmodule

module fetch_trace_filter_chk (
  input logic       clk,
  input logic       rst,
  input logic       fetch_vld,
  input logic       fetch_cof,
  input logic       fetch_ind,
  input logic [1:0] show_mode,
  input logic       sync_in,
  input logic       show_req,
  input logic       mark_req
);

  logic seen_sync;

  always_ff @(posedge clk) seen_sync <= sync_in;

  p_rst_quiet_r1: assert property (@(posedge clk) rst |=> (!show_req && !mark_req));

  p_all_fetch_r2: assert property (@(posedge clk) disable iff (rst)
    (fetch_vld && show_mode == 2'b00) |=> show_req);

  p_cof_only_r3: assert property (@(posedge clk) disable iff (rst)
    (fetch_vld && show_mode == 2'b01 && !fetch_cof) |=> !show_req);

  p_off_low_r5: assert property (@(posedge clk) disable iff (rst)
    (show_mode == 2'b11 && !sync_in) |=> !show_req);

  p_edge_mark_r7: assert property (@(posedge clk) disable iff (rst)
    (sync_in != seen_sync) |=> mark_req);

  p_no_edge_r7: assert property (@(posedge clk) disable iff (rst)
    (sync_in == seen_sync) |=> !mark_req);

  p_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !fetch_vld |=> !show_req);

endmodule

bind fetch_trace_filter fetch_trace_filter_chk u_chk (.*);

// File: tb/tb_fetch_trace_filter.sv
module tb_fetch_trace_filter;

  logic       clk = 1'b0;
  logic       rst;
  logic       fetch_vld, fetch_cof, fetch_ind, sync_in;
  logic [1:0] show_mode;
  logic       show_req, mark_req;

  int total = 0;
  int bad   = 0;
  logic  model_sync;
  logic  [1:0] exp_q[$];
  string tag_q[$];
  bit    done = 0;

  always #4 clk = ~clk;

  fetch_trace_filter dut (
    .clk(clk), .rst(rst), .fetch_vld(fetch_vld), .fetch_cof(fetch_cof),
    .fetch_ind(fetch_ind), .show_mode(show_mode), .sync_in(sync_in),
    .show_req(show_req), .mark_req(mark_req)
  );

  function automatic logic model_show(logic v, logic c, logic i, logic [1:0] m, logic s);
    if (!v) return 1'b0;
    case (m)
      2'b00:   return 1'b1;
      2'b01:   return c;
      2'b10:   return c && i;
      default: return s && c && i;
    endcase
  endfunction

  task automatic step(logic v, logic c, logic i, logic [1:0] m, logic s, string tag);
    @(negedge clk);
    fetch_vld = v; fetch_cof = c; fetch_ind = i; show_mode = m; sync_in = s;
    exp_q.push_back({model_show(v, c, i, m, s), s != model_sync});
    tag_q.push_back(tag);
    model_sync = s;
  endtask

  task automatic four_kinds(logic [1:0] m, logic s, string tag);
    step(1, 0, 0, m, s, tag);
    step(1, 1, 0, m, s, tag);
    step(1, 1, 1, m, s, tag);
    step(1, 0, 1, m, s, tag);
    step(0, 1, 1, m, s, "R8");
  endtask

  always @(posedge clk) begin
    #1;
    if (!rst && exp_q.size() > 0) begin
      logic [1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if ({show_req, mark_req} !== e) begin
        bad++;
        $display("FAIL %s: show/mark actual=%b%b expected=%b%b", t, show_req, mark_req, e[1], e[0]);
      end
    end
  end

  initial begin
    rst = 1'b1; fetch_vld = 0; fetch_cof = 0; fetch_ind = 0; show_mode = 2'b00; sync_in = 1'b1;
    repeat (3) @(negedge clk);
    total++;
    if (show_req !== 1'b0 || mark_req !== 1'b0) begin
      bad++;
      $display("FAIL R1: reset outputs actual=%b%b expected=00", show_req, mark_req);
    end
    model_sync = 1'b1;
    rst = 1'b0;
    step(0, 0, 0, 2'b00, 1, "R1");
    step(0, 0, 0, 2'b00, 1, "R10");
    step(0, 0, 0, 2'b00, 1, "R10");
    four_kinds(2'b00, 1, "R2");
    four_kinds(2'b01, 1, "R3");
    four_kinds(2'b10, 1, "R4");
    four_kinds(2'b11, 1, "R6");
    step(0, 0, 0, 2'b11, 0, "R7");
    four_kinds(2'b11, 0, "R5");
    step(0, 0, 0, 2'b11, 1, "R7");
    step(0, 0, 0, 2'b11, 0, "R7");
    step(0, 0, 0, 2'b11, 1, "R7");
    step(0, 0, 0, 2'b11, 1, "R7");
    step(0, 0, 0, 2'b11, 1, "R7");
    step(1, 0, 0, 2'b00, 0, "R9");
    step(1, 1, 0, 2'b01, 1, "R9");
    step(1, 1, 1, 2'b11, 0, "R9");
    step(1, 1, 1, 2'b11, 1, "R9");
    step(0, 0, 0, 2'b00, 1, "R8");
    step(0, 0, 0, 2'b00, 1, "R8");
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule